// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This block generates several pulse-width-modulated outputs from a single up-counter. The counter runs from a programmable start value up to a programmable period limit, then wraps back to the start value. Every channel compares the live count against its own threshold. A channel is driven to its active level from the start of each period until the count reaches that threshold. Because all channels share one counter, they all share one period. Each channel keeps its own duty, polarity, mask and enable.

The counter advances on one of three tick sources, or not at all. The sources are every system clock cycle, a fixed-rate tick enable, and an external tick enable. The chosen source then passes through a power-of-two prescaler. Software programs the block through a 32-bit register port with byte addresses on word boundaries. A protection latch blocks writes to the timing and channel setup registers. The output mask, the protection-arm register and the protection-release register can always be written.

New period and threshold values are held in buffer registers. They reach the working copies only when the counter wraps, or while the counter is stopped. A period that is already running is therefore never cut short.

Top module: `shared_period_pwm`

## Requirements
- R1: After reset, every output is low, the mask register (0x18) reads all ones, the protection flag in the arm register (0x10, bit 0) reads 1, the period register (0x08) reads 0xFFFF and the count register (0x04) reads 0.
- R2: Control register 0x00 bits [1:0] select the counting source: 0 stops the counter, 1 counts every clock, 2 counts on `fix_tick`, 3 counts on `ext_tick`.
- R3: Control register bits [4:2] hold a prescale p, and the counter advances once per 2^p source ticks.
- R4: The counter counts from the start register (0x0C) up to the period value and then reloads the start value, so one period lasts period+1-start ticks. While the source is 0, the counter holds the start value.
- R5: Channel n is in PWM mode only when bits 0 and 1 of its mode register (0x40+4n) are both 1. In PWM mode its raw level is 1 while count < its threshold (0x80+4n). Outside PWM mode the raw level is 0.
- R6: A threshold of 0 gives a raw level that is always 0. A threshold above the period value gives a raw level that is always 1.
- R7: Bit n of the polarity register (0x1C) inverts channel n. The output of an idle or masked channel equals its polarity bit.
- R8: Mask bit n set forces channel n to its idle level. The mask register can be written even while protection is on.
- R9: While protection is on, writes to the control, period, start, polarity, channel mode and channel threshold registers are dropped. Writing 1 to bit 0 of register 0x14 turns protection off. Writing 1 to bit 0 of register 0x10 turns it on.
- R10: With the enable option built in, control bit 16+n enables channel n, and a cleared bit holds the channel at its idle level. These enable bits reset to 0.
- R11: A new period or threshold written while the counter runs takes effect at the next wrap. The current period finishes with the old values.
- R12: Reading register 0x04 returns the live count on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fix_tick | input | 1 | Fixed-rate tick enable (source 2) |
| ext_tick | input | 1 | External tick enable (source 3) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address, low two bits ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 8 | Channel outputs |

## Verification
The bench builds the block with its defaults: eight channels, a 16-bit counter, a 3-bit prescale field and the per-channel enable option present. With eight channels, the vector table can put the active channel on the lowest, a middle and the highest index. This shows that each channel's enable, mask and polarity bits decode at the right position. With the enable option built in, R10 can be checked. The 16-bit counter reaches the reset period of 0xFFFF, and small programmed periods keep every measured window short. Because the tick sources are tick-enable inputs, the bench can drive the fixed and external sources at different rates and combine them with the prescaler.

// File: rtl/spp_pkg.sv
package spp_pkg;

   typedef enum logic [1:0] {
      SRC_OFF = 2'd0,
      SRC_SYS = 2'd1,
      SRC_FIX = 2'd2,
      SRC_EXT = 2'd3
   } src_sel_e;

   // word indices (byte address >> 2)
   localparam int W_CTRL       = 0;
   localparam int W_COUNT      = 1;
   localparam int W_PERIOD     = 2;
   localparam int W_START      = 3;
   localparam int W_GUARD      = 4;
   localparam int W_RELEASE    = 5;
   localparam int W_MASK       = 6;
   localparam int W_POL        = 7;
   localparam int W_CHMODE_BASE = 16;
   localparam int W_CHVAL_BASE  = 32;

   localparam int EN_LSB = 16;

endpackage

// File: rtl/spp_tick_gen.sv
module spp_tick_gen
   import spp_pkg::*;
#(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  src_sel_e        sel,
   input  logic [PS_W-1:0] ps,
   input  logic            fix_tick,
   input  logic            ext_tick,
   output logic            tick
);

   localparam int PRE_W = (1 << PS_W) - 1;

   logic             src;
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] pre_mask;

   always_comb begin
      case (sel)
         SRC_SYS: src = 1'b1;
         SRC_FIX: src = fix_tick;
         SRC_EXT: src = ext_tick;
         default: src = 1'b0;
      endcase
   end

   // low p bits all ones -> 2^p source ticks have elapsed
   assign pre_mask = ~({PRE_W{1'b1}} << ps);
   assign tick     = src && ((pre_q & pre_mask) == pre_mask);

   always_ff @(posedge clk) begin
      if (!rst_n)                pre_q <= '0;
      else if (sel == SRC_OFF)   pre_q <= '0;
      else if (src)              pre_q <= pre_q + 1'b1;
   end

endmodule

// File: rtl/spp_counter.sv
module spp_counter #(
   parameter int          CNT_W   = 16,
   parameter logic [15:0] MOD_RST = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] start_val,
   input  logic [CNT_W-1:0] mod_buf,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] mod_act,
   output logic             load
);

   logic wrap;

   assign wrap = run && tick && (cnt >= mod_act);
   assign load = !run || wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         mod_act <= CNT_W'(MOD_RST);
      end else if (load) begin
         cnt     <= start_val;
         mod_act <= mod_buf;
      end else if (tick) begin
         cnt     <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/spp_channel.sv
module spp_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] thr_buf,
   input  logic [CNT_W-1:0] cnt,
   input  logic [1:0]       mode,
   input  logic             en,
   input  logic             mask,
   input  logic             pol,
   output logic             out
);

   logic [CNT_W-1:0] thr_act;
   logic             raw;

   always_ff @(posedge clk) begin
      if (!rst_n)    thr_act <= '0;
      else if (load) thr_act <= thr_buf;
   end

   assign raw = (mode == 2'b11) && en && (cnt < thr_act);
   assign out = mask ? pol : (raw ^ pol);

endmodule

// File: rtl/shared_period_pwm.sv
module shared_period_pwm
   import spp_pkg::*;
#(
   parameter int          NCH        = 8,
   parameter int          CNT_W      = 16,
   parameter int          PS_W       = 3,
   parameter int          ADDR_W     = 8,
   parameter bit          CH_GATE_EN = 1'b1,
   parameter logic [15:0] MOD_RST    = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fix_tick,
   input  logic              ext_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCH-1:0]    pwm_out
);

   localparam int WORD_W = ADDR_W - 2;

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("NCH must be 1..16");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must be 2..16");
   end
   if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
      $error("PS_W must be 1..4");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end

   logic [WORD_W-1:0] word;
   logic              wr_open;
   logic              protect_q;
   src_sel_e          sel_q;
   logic [PS_W-1:0]   ps_q;
   logic [CNT_W-1:0]  mod_q;
   logic [CNT_W-1:0]  init_q;
   logic [NCH-1:0]    mask_q;
   logic [NCH-1:0]    pol_q;
   logic [1:0]        chmode_q [NCH];
   logic [CNT_W-1:0]  chval_q  [NCH];
   logic [NCH-1:0]    ch_en;
   logic              tick;
   logic              run;
   logic              load;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  mod_act;
   logic              unused_bits;

   assign word        = bus_addr[ADDR_W-1:2];
   assign wr_open     = bus_wr && !protect_q;
   assign run         = (sel_q != SRC_OFF);
   assign unused_bits = ^{bus_addr[1:0], bus_wdata};

   // protection latch
   always_ff @(posedge clk) begin
      if (!rst_n)
         protect_q <= 1'b1;
      else if (bus_wr && word == WORD_W'(W_GUARD) && bus_wdata[0])
         protect_q <= 1'b1;
      else if (bus_wr && word == WORD_W'(W_RELEASE) && bus_wdata[0])
         protect_q <= 1'b0;
   end

   // always-writable mask
   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '1;
      else if (bus_wr && word == WORD_W'(W_MASK))
         mask_q <= bus_wdata[NCH-1:0];
   end

   // guarded setup registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= SRC_OFF;
         ps_q   <= '0;
         mod_q  <= CNT_W'(MOD_RST);
         init_q <= '0;
         pol_q  <= '0;
         for (int n = 0; n < NCH; n++) begin
            chmode_q[n] <= '0;
            chval_q[n]  <= '0;
         end
      end else if (wr_open) begin
         if (word == WORD_W'(W_CTRL)) begin
            sel_q <= src_sel_e'(bus_wdata[1:0]);
            ps_q  <= bus_wdata[2 +: PS_W];
         end
         if (word == WORD_W'(W_PERIOD)) mod_q  <= bus_wdata[CNT_W-1:0];
         if (word == WORD_W'(W_START))  init_q <= bus_wdata[CNT_W-1:0];
         if (word == WORD_W'(W_POL))    pol_q  <= bus_wdata[NCH-1:0];
         for (int n = 0; n < NCH; n++) begin
            if (word == WORD_W'(W_CHMODE_BASE + n)) chmode_q[n] <= bus_wdata[1:0];
            if (word == WORD_W'(W_CHVAL_BASE + n))  chval_q[n]  <= bus_wdata[CNT_W-1:0];
         end
      end
   end

   // optional per-channel enable bits
   if (CH_GATE_EN) begin : g_gate
      logic [NCH-1:0] en_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            en_q <= '0;
         else if (wr_open && word == WORD_W'(W_CTRL))
            en_q <= bus_wdata[EN_LSB +: NCH];
      end
      assign ch_en = en_q;
   end else begin : g_nogate
      assign ch_en = '1;
   end

   spp_tick_gen #(.PS_W(PS_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel_q),
      .ps       (ps_q),
      .fix_tick (fix_tick),
      .ext_tick (ext_tick),
      .tick     (tick)
   );

   spp_counter #(.CNT_W(CNT_W), .MOD_RST(MOD_RST)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (tick),
      .start_val (init_q),
      .mod_buf   (mod_q),
      .cnt       (cnt),
      .mod_act   (mod_act),
      .load      (load)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      spp_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (load),
         .thr_buf (chval_q[g]),
         .cnt     (cnt),
         .mode    (chmode_q[g]),
         .en      (ch_en[g]),
         .mask    (mask_q[g]),
         .pol     (pol_q[g]),
         .out     (pwm_out[g])
      );
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (word)
         WORD_W'(W_CTRL): begin
            bus_rdata[1:0]            = sel_q;
            bus_rdata[2 +: PS_W]      = ps_q;
            bus_rdata[EN_LSB +: NCH]  = ch_en;
         end
         WORD_W'(W_COUNT):  bus_rdata[CNT_W-1:0] = cnt;
         WORD_W'(W_PERIOD): bus_rdata[CNT_W-1:0] = mod_q;
         WORD_W'(W_START):  bus_rdata[CNT_W-1:0] = init_q;
         WORD_W'(W_GUARD):  bus_rdata[0]         = protect_q;
         WORD_W'(W_MASK):   bus_rdata[NCH-1:0]   = mask_q;
         WORD_W'(W_POL):    bus_rdata[NCH-1:0]   = pol_q;
         default: begin
            for (int n = 0; n < NCH; n++) begin
               if (word == WORD_W'(W_CHMODE_BASE + n)) bus_rdata[1:0] = chmode_q[n];
               if (word == WORD_W'(W_CHVAL_BASE + n))  bus_rdata[CNT_W-1:0] = chval_q[n];
            end
         end
      endcase
   end

endmodule

// File: rtl/spp_checker.sv
module spp_checker
   import spp_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NCH-1:0]    pwm_out,
   input logic [NCH-1:0]    mask,
   input logic [NCH-1:0]    pol,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  mod_act,
   input logic [CNT_W-1:0]  mod_buf,
   input logic [CNT_W-1:0]  init,
   input logic              run,
   input logic              tick,
   input logic              protect,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr
);

   for (genvar g = 0; g < NCH; g++) begin : g_mask_chk
      // R8 / R7: a masked channel sits at its polarity level
      p_mask_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
         mask[g] |-> (pwm_out[g] == pol[g]));
   end

   // R4: after the terminal tick the counter holds the start value
   p_wrap_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && (cnt >= mod_act)) |=> (cnt == $past(init)));

   // R4: a stopped counter holds the start value
   p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == $past(init)));

   // R11: working period only changes at a wrap or while stopped
   p_buf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(tick && (cnt >= mod_act))) |=> $stable(mod_act));

   // R9: a guarded period write is dropped
   p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (protect && bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(W_PERIOD)))
      |=> $stable(mod_buf));

endmodule

bind shared_period_pwm spp_checker #(
   .NCH    (NCH),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwm_out  (pwm_out),
   .mask     (mask_q),
   .pol      (pol_q),
   .cnt      (cnt),
   .mod_act  (mod_act),
   .mod_buf  (mod_q),
   .init     (init_q),
   .run      (run),
   .tick     (tick),
   .protect  (protect_q),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr)
);

// File: tb/tb_shared_period_pwm.sv
`timescale 1ns/1ps
module tb_shared_period_pwm;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fix_tick = 1'b0;
   logic        ext_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pwm_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   shared_period_pwm dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .fix_tick  (fix_tick),
      .ext_tick  (ext_tick),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   // tick sources: fixed every 3rd cycle, external every 5th
   int fc = 0;
   int ec = 0;
   always @(negedge clk) begin
      fc = (fc == 2) ? 0 : fc + 1;
      ec = (ec == 4) ? 0 : ec + 1;
      fix_tick = (fc == 2);
      ext_tick = (ec == 4);
   end

   localparam logic [7:0] A_CTRL = 8'h00, A_COUNT = 8'h04, A_PERIOD = 8'h08,
                          A_START = 8'h0C, A_GUARD = 8'h10, A_REL = 8'h14,
                          A_MASK = 8'h18, A_POL = 8'h1C;

   typedef struct packed {
      logic [15:0] per;
      logic [15:0] thr;
      logic        inv;
      logic [2:0]  ch;
      logic [2:0]  ps;
      logic [1:0]  src;
      logic [15:0] win;
      logic [15:0] hi;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{16'd9,  16'd3,  1'b0, 3'd0, 3'd0, 2'd1, 16'd10, 16'd3},
      '{16'd9,  16'd0,  1'b0, 3'd0, 3'd0, 2'd1, 16'd10, 16'd0},
      '{16'd9,  16'd10, 1'b0, 3'd0, 3'd0, 2'd1, 16'd10, 16'd10},
      '{16'd15, 16'd5,  1'b1, 3'd3, 3'd0, 2'd1, 16'd16, 16'd11},
      '{16'd4,  16'd2,  1'b0, 3'd7, 3'd2, 2'd1, 16'd20, 16'd8},
      '{16'd5,  16'd3,  1'b0, 3'd5, 3'd0, 2'd2, 16'd18, 16'd9},
      '{16'd3,  16'd1,  1'b0, 3'd2, 3'd1, 2'd3, 16'd40, 16'd10},
      '{16'd0,  16'd1,  1'b0, 3'd1, 3'd0, 2'd1, 16'd1,  16'd1},
      '{16'd7,  16'd8,  1'b1, 3'd6, 3'd0, 2'd1, 16'd8,  16'd0}
   };

   function automatic string vec_tag(input int i);
      case (i)
         0:       return "R5 duty";
         1:       return "R6 zero threshold";
         2:       return "R6 threshold above period";
         3:       return "R7 inverted";
         4:       return "R3 prescale 4";
         5:       return "R2 fixed source";
         6:       return "R2 external source with R3 prescale";
         7:       return "R4 single-tick period";
         default: return "R6 R7 inverted always-on";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic setup(input logic [15:0] per, input logic [15:0] thr, input logic inv,
                        input int ch, input logic [2:0] ps, input logic [1:0] src,
                        input logic [7:0] en, input logic [1:0] md, input logic [15:0] st);
      wr(A_CTRL, {8'h0, en, 16'h0});
      wr(A_PERIOD, {16'h0, per});
      wr(A_START, {16'h0, st});
      wr(8'h40 + 8'(4 * ch), {30'h0, md});
      wr(8'h80 + 8'(4 * ch), {16'h0, thr});
      wr(A_POL, {24'h0, 8'(inv) << ch});
      wr(A_MASK, {24'h0, ~(8'h1 << ch)});
      wr(A_CTRL, {8'h0, en, 11'h0, ps, src});
   endtask

   task automatic measure(input int ch, input int win, output int h);
      h = 0;
      repeat (2 * win + 4) @(negedge clk);
      repeat (win) begin
         @(negedge clk);
         #1;
         h += int'(pwm_out[ch]);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int h;
      bit found;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 outputs", {24'h0, pwm_out}, 32'h0);
      rd(A_MASK, d);   check("R1 mask", d, 32'hFF);
      rd(A_GUARD, d);  check("R1 protection", d, 32'h1);
      rd(A_PERIOD, d); check("R1 period", d, 32'hFFFF);
      rd(A_COUNT, d);  check("R1 count", d, 32'h0);

      // R9 locked write dropped, R8 mask still writable
      wr(A_PERIOD, 32'h5);
      rd(A_PERIOD, d); check("R9 locked period", d, 32'hFFFF);
      wr(A_MASK, 32'hFE);
      rd(A_MASK, d);   check("R8 mask writable when locked", d, 32'hFE);
      wr(A_MASK, 32'hFF);
      wr(A_REL, 32'h1);
      rd(A_GUARD, d);  check("R9 release", d, 32'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         setup(VEC[i].per, VEC[i].thr, VEC[i].inv, int'(VEC[i].ch), VEC[i].ps,
               VEC[i].src, 8'hFF, 2'b11, 16'h0);
         measure(int'(VEC[i].ch), int'(VEC[i].win), h);
         check(vec_tag(i), h, {16'h0, VEC[i].hi});
         check("R8 other channels idle", {24'h0, pwm_out & ~(8'h1 << VEC[i].ch)}, 32'h0);
      end

      // R9 re-arm blocks polarity; R8 mask forces idle level = polarity
      wr(A_GUARD, 32'h1);
      wr(A_POL, 32'hFF);
      rd(A_POL, d);    check("R9 re-armed polarity", d, 32'h40);
      wr(A_MASK, 32'hFF);
      @(negedge clk); #1;
      check("R8 R7 masked idle level", {24'h0, pwm_out}, 32'h40);
      wr(A_REL, 32'h1);

      // R10 channel enable bit cleared
      setup(16'd9, 16'd3, 1'b0, 0, 3'd0, 2'd1, 8'hFE, 2'b11, 16'h0);
      measure(0, 10, h);
      check("R10 disabled channel", h, 32'd0);

      // R5 incomplete mode bits
      setup(16'd9, 16'd3, 1'b0, 0, 3'd0, 2'd1, 8'hFF, 2'b01, 16'h0);
      measure(0, 10, h);
      check("R5 mode 01 idle", h, 32'd0);
      setup(16'd9, 16'd3, 1'b0, 0, 3'd0, 2'd1, 8'hFF, 2'b10, 16'h0);
      measure(0, 10, h);
      check("R5 mode 10 idle", h, 32'd0);

      // R4 nonzero start value: period 8 ticks, active on counts 2..4
      setup(16'd9, 16'd5, 1'b0, 0, 3'd0, 2'd1, 8'hFF, 2'b11, 16'd2);
      measure(0, 8, h);
      check("R4 start value period", h, 32'd3);

      // R4 / R12 stopped counter holds start
      wr(A_CTRL, 32'h00FF_0000);
      wr(A_START, 32'd5);
      @(negedge clk);
      rd(A_COUNT, d);  check("R4 stopped holds start", d, 32'd5);

      // R11 buffered period, R12 live count
      setup(16'd9, 16'd3, 1'b0, 0, 3'd0, 2'd1, 8'hFF, 2'b11, 16'h0);
      wr(A_PERIOD, 32'd19);
      found = 1'b0;
      for (int k = 0; k < 30 && !found; k++) begin
         @(negedge clk);
         rd(A_COUNT, d);
         if (d == 32'd9) found = 1'b1;
      end
      check("R11 old period reaches 9", {31'h0, found}, 32'h1);
      @(negedge clk); rd(A_COUNT, d);
      check("R11 old period wraps", d, 32'd0);
      @(negedge clk); rd(A_COUNT, d);
      check("R12 live count", d, 32'd1);
      repeat (18) @(negedge clk);
      rd(A_COUNT, d);  check("R11 new period top", d, 32'd19);
      @(negedge clk); rd(A_COUNT, d);
      check("R11 new period wraps", d, 32'd0);

      finish_run();
   end

endmodule